// File: doc/BRIEF.md
# Multi-Locality Access Arbiter

This block controls which of five requesters ("localities") owns a shared, memory-mapped security-module interface at any moment. Each locality sees its own copy of a small register window, picked by the upper address bits, and within it a one-byte access register. Through that register a locality can ask for the interface, check whether it holds it, see whether someone else is waiting, and hand it back. The block keeps one grant at most, picks among waiting requesters by fixed priority, and drives the index of the owner together with a one-cycle pulse whenever ownership changes.

After reset the block models a self-initialization phase. For a set number of cycles every read returns zero and every write is dropped. Once this phase ends, the valid flag in the access register reads 1, and software may then rely on the other bits. A shared scratch byte shows how ownership protects the rest of the window: only the owner can change it, and any locality can read it.

Top module: `locality_arbiter`

## Requirements
- R1: While rst is high and on the first cycle after it, held, grant_change and rdata are all 0.
- R2: For INIT_CYCLES clock edges after reset every read returns 0x00. After that, bit 7 of the access register (offset 0x000) reads 1 in every window 0..4.
- R3: Writes made before the valid flag is set have no effect. A request written then is not held pending once valid rises.
- R4: Address bits [14:12] select the locality window, so offsets repeat every 0x1000. Windows 5..7 and undefined offsets read 0x00, and writes to them are ignored.
- R5: Writing an access-register byte with bit 1 set records a request for that window's locality. If no locality is active, the grant happens on the clock edge after the write edge: held=1, active_idx=locality.
- R6: When several requests are pending at a grant decision, the highest-numbered locality wins.
- R7: Access register bit 5 reads 1 only in the window of the active locality. Bit 2 reads 1 when a locality other than the window's own has a request pending. Bit 1 reads 1 while the window's own request waits.
- R8: Writing bit 5 in the active locality's access register releases the grant on that same edge. The highest pending request takes over at once; if none is pending, held drops to 0.
- R9: Writing bit 5 from a window that is not active changes nothing.
- R10: grant_change is high for exactly the one cycle that follows each edge on which held or active_idx changed, and is low otherwise.
- R11: The scratch byte at offset 0x004 takes writes only from the active locality's window. Writes from other windows are ignored. It reads back the same value through any window 0..4.
- R12: rdata is registered. It shows the value addressed by a read on the edge where rd_en is sampled high and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 15 | Byte address; [14:12] locality window, [11:0] offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| held | output | 1 | Some locality currently owns the interface |
| active_idx | output | 3 | Index of the owning locality (meaningful when held) |
| grant_change | output | 1 | One-cycle pulse after any change of ownership |

## Verification
A release and a read update their results on the very edge that samples the strobe, so the bench checks them at the falling edge right after that write or read. A grant from idle needs one more edge after the request's write edge. The bench therefore checks held=0 at the first falling edge and the new owner, together with the grant_change pulse, at the next one. grant_change is then checked low one falling edge later. The valid flag is probed before and well after the initialization window, and the directed tasks read the access registers of several windows so that every bit's meaning is seen at the ports.

// File: rtl/locarb_pkg.sv
package locarb_pkg;
  // Access register bit positions (software decodes these)
  localparam int ACC_VALID_BIT  = 7;
  localparam int ACC_ACTIVE_BIT = 5;
  localparam int ACC_OTHER_BIT  = 2;
  localparam int ACC_REQ_BIT    = 1;
  // Register offsets inside a locality window
  localparam int OFS_ACCESS  = 'h000;
  localparam int OFS_SCRATCH = 'h004;
endpackage

// File: rtl/locarb_init_timer.sv
module locarb_init_timer #(
  parameter int INIT_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  output logic valid
);
  localparam int CNT_W = $clog2(INIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INIT_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      valid <= 1'b0;
    end else if (!valid) begin
      if (cnt == LAST) valid <= 1'b1;
      else             cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/locarb_grant_core.sv
module locarb_grant_core #(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_LOC-1:0] req_set,
  input  logic [NUM_LOC-1:0] rel_try,
  input  logic [NUM_LOC-1:0] act_vec,
  output logic [NUM_LOC-1:0] pend,
  output logic               held,
  output logic [LOC_W-1:0]   idx,
  output logic               chg
);
  logic [LOC_W-1:0]   top_idx;
  logic [NUM_LOC-1:0] top_oh;
  logic               any_pend, rel;
  logic [NUM_LOC-1:0] pend_n;
  logic               held_n;
  logic [LOC_W-1:0]   idx_n;
  logic               chg_n;

  // Highest-numbered pending locality
  always_comb begin
    top_idx = '0;
    top_oh  = '0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (pend[i]) begin
        top_idx = LOC_W'(i);
        top_oh  = '0;
        top_oh[i] = 1'b1;
      end
    end
  end

  assign any_pend = |pend;
  assign rel      = |(rel_try & act_vec);

  always_comb begin
    pend_n = pend | (req_set & ~act_vec);
    held_n = held;
    idx_n  = idx;
    chg_n  = 1'b0;
    if (held && rel) begin
      chg_n = 1'b1;
      if (any_pend) begin
        idx_n  = top_idx;
        pend_n = pend_n & ~top_oh;
      end else begin
        held_n = 1'b0;
      end
    end else if (!held && any_pend) begin
      chg_n  = 1'b1;
      held_n = 1'b1;
      idx_n  = top_idx;
      pend_n = pend_n & ~top_oh;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      held <= 1'b0;
      idx  <= '0;
      chg  <= 1'b0;
    end else begin
      pend <= pend_n;
      held <= held_n;
      idx  <= idx_n;
      chg  <= chg_n;
    end
  end
endmodule

// File: rtl/locarb_regfile.sv
module locarb_regfile
  import locarb_pkg::*;
#(
  parameter int NUM_LOC = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               valid,
  input  logic               rd_en,
  input  logic               wr_en,
  input  logic               acc_hit,
  input  logic               scr_hit,
  input  logic [NUM_LOC-1:0] win_sel,
  input  logic [NUM_LOC-1:0] act_vec,
  input  logic [NUM_LOC-1:0] pend,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata
);
  logic [7:0] scratch;
  logic [7:0] acc_byte;
  logic [7:0] rd_val;
  logic       win_owns;

  assign win_owns = |(win_sel & act_vec);

  always_comb begin
    acc_byte = '0;
    acc_byte[ACC_VALID_BIT]  = 1'b1;
    acc_byte[ACC_ACTIVE_BIT] = win_owns;
    acc_byte[ACC_OTHER_BIT]  = |(pend & ~win_sel);
    acc_byte[ACC_REQ_BIT]    = |(pend & win_sel);
  end

  always_comb begin
    if (!valid)       rd_val = '0;
    else if (acc_hit) rd_val = acc_byte;
    else if (scr_hit) rd_val = scratch;
    else              rd_val = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scratch <= '0;
      rdata   <= '0;
    end else begin
      if (wr_en && valid && scr_hit && win_owns) scratch <= wdata;
      if (rd_en) rdata <= rd_val;
    end
  end
endmodule

// File: rtl/locality_arbiter.sv
module locality_arbiter
  import locarb_pkg::*;
#(
  parameter int NUM_LOC     = 5,
  parameter int ADDR_W      = 15,
  parameter int WIN_LSB     = 12,
  parameter int INIT_CYCLES = 16,
  parameter int LOC_W       = $clog2(NUM_LOC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              held,
  output logic [LOC_W-1:0]  active_idx,
  output logic              grant_change
);
  localparam int WIN_W = ADDR_W - WIN_LSB;

  logic [WIN_W-1:0]   win;
  logic [WIN_LSB-1:0] ofs;
  logic [NUM_LOC-1:0] win_sel, act_vec, pend, req_set, rel_try;
  logic               win_ok, acc_hit, scr_hit, valid, acc_wr;

  assign win = addr[ADDR_W-1:WIN_LSB];
  assign ofs = addr[WIN_LSB-1:0];

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_win
    assign win_sel[i] = (win == WIN_W'(i));
    assign act_vec[i] = held && (active_idx == LOC_W'(i));
  end

  assign win_ok  = |win_sel;
  assign acc_hit = win_ok && (ofs == WIN_LSB'(OFS_ACCESS));
  assign scr_hit = win_ok && (ofs == WIN_LSB'(OFS_SCRATCH));
  assign acc_wr  = wr_en && valid && acc_hit;
  assign req_set = (acc_wr && wdata[ACC_REQ_BIT])    ? win_sel : '0;
  assign rel_try = (acc_wr && wdata[ACC_ACTIVE_BIT]) ? win_sel : '0;

  locarb_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .valid(valid)
  );

  locarb_grant_core #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_core (
    .clk(clk), .rst(rst), .req_set(req_set), .rel_try(rel_try),
    .act_vec(act_vec), .pend(pend), .held(held), .idx(active_idx),
    .chg(grant_change)
  );

  locarb_regfile #(.NUM_LOC(NUM_LOC)) u_regs (
    .clk(clk), .rst(rst), .valid(valid), .rd_en(rd_en), .wr_en(wr_en),
    .acc_hit(acc_hit), .scr_hit(scr_hit), .win_sel(win_sel),
    .act_vec(act_vec), .pend(pend), .wdata(wdata), .rdata(rdata)
  );
endmodule

// File: rtl/locality_arbiter_chk.sv
module locality_arbiter_chk #(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               valid,
  input logic [NUM_LOC-1:0] pend,
  input logic               held,
  input logic [LOC_W-1:0]   idx,
  input logic               chg,
  input logic               rd_en,
  input logic [7:0]         rdata
);
  assert_idle_grant_R5: assert property (@(posedge clk) disable iff (rst)
    (valid && !held && (|pend)) |=> held);

  assert_pulse_means_change_R10: assert property (@(posedge clk) disable iff (rst)
    chg |-> ((held != $past(held)) || (idx != $past(idx))));

  assert_change_gives_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    (held != $past(held)) |-> chg);

  assert_nothing_before_valid_R3: assert property (@(posedge clk) disable iff (rst)
    !valid |-> (!held && (pend == '0)));

  assert_dark_reads_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !valid) |=> (rdata == 8'h00));

  assert_idx_in_range_R8: assert property (@(posedge clk) disable iff (rst)
    held |-> (int'(idx) < NUM_LOC));
endmodule

bind locality_arbiter locality_arbiter_chk #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_chk (
  .clk(clk), .rst(rst), .valid(valid), .pend(pend), .held(held),
  .idx(active_idx), .chg(grant_change), .rd_en(rd_en), .rdata(rdata)
);

// File: tb/tb_locality_arbiter.sv
module tb_locality_arbiter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        held;
  logic [2:0]  active_idx;
  logic        grant_change;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  locality_arbiter dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .held(held), .active_idx(active_idx),
    .grant_change(grant_change)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic do_wr(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [14:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset_and_init();
    logic [7:0] v;
    repeat (3) @(negedge clk);
    check("R1 held in reset", held, 0);
    check("R1 pulse in reset", grant_change, 0);
    check("R1 rdata in reset", rdata, 0);
    rst = 1'b0;
    check("R1 held after reset", held, 0);
    do_rd(15'h0000, v);
    check("R2 read during init", v, 8'h00);
    do_wr(15'h0000, 8'h02);          // R3: dropped request
    do_wr(15'h0004, 8'h77);          // R3: dropped scratch write
    repeat (40) @(negedge clk);
    check("R3 no grant from early write", held, 0);
    do_rd(15'h0000, v);
    check("R2 valid set, R3 no request bit", v, 8'h80);
    do_rd(15'h4000, v);
    check("R2 valid in window 4", v, 8'h80);
    do_rd(15'h1004, v);
    check("R3 scratch untouched", v, 8'h00);
  endtask

  task automatic t_grant_idle();
    do_wr(15'h2000, 8'h02);
    check("R5 not granted on write edge", held, 0);
    @(negedge clk);
    check("R5 granted next edge", held, 1);
    check("R5 owner index", active_idx, 2);
    check("R10 pulse on grant", grant_change, 1);
    @(negedge clk);
    check("R10 pulse one cycle", grant_change, 0);
  endtask

  task automatic t_pending_bits();
    logic [7:0] v;
    do_wr(15'h1000, 8'h02);
    do_wr(15'h3000, 8'h02);
    check("R5 owner kept while others ask", active_idx, 2);
    do_rd(15'h2000, v);
    check("R7 owner window", v, 8'hA4);
    do_rd(15'h1000, v);
    check("R7 waiting window 1", v, 8'h86);
    do_rd(15'h0000, v);
    check("R7 idle window 0", v, 8'h84);
    do_rd(15'h2FFF, v);
    check("R4 undefined offset", v, 8'h00);
  endtask

  task automatic t_foreign_release();
    logic [7:0] v;
    do_wr(15'h1000, 8'h20);
    check("R9 still held", held, 1);
    check("R9 owner unchanged", active_idx, 2);
    check("R9 no pulse", grant_change, 0);
    do_rd(15'h1000, v);
    check("R9 window 1 still waiting", v, 8'h86);
  endtask

  task automatic t_scratch_and_alias();
    logic [7:0] v;
    do_wr(15'h1004, 8'h55);
    do_rd(15'h0004, v);
    check("R11 non-owner write ignored", v, 8'h00);
    do_wr(15'h2004, 8'h3C);
    do_rd(15'h4004, v);
    check("R11 owner write seen in window 4", v, 8'h3C);
    do_wr(15'h5000, 8'h02);
    do_rd(15'h5000, v);
    check("R4 window 5 reads zero", v, 8'h00);
    do_rd(15'h4000, v);
    check("R4 window 5 request ignored", v, 8'h84);
    do_wr(15'h7004, 8'hFF);
    do_rd(15'h0004, v);
    check("R4 window 7 write ignored", v, 8'h3C);
    // R12: rdata holds after the read
    repeat (2) @(negedge clk);
    check("R12 rdata holds", rdata, 8'h3C);
  endtask

  task automatic t_release_chain();
    logic [7:0] v;
    do_wr(15'h2000, 8'h20);
    check("R8 handoff held", held, 1);
    check("R6 highest pending wins", active_idx, 3);
    check("R10 pulse on handoff", grant_change, 1);
    @(negedge clk);
    check("R10 handoff pulse one cycle", grant_change, 0);
    do_wr(15'h3000, 8'h20);
    check("R8 handoff to 1", active_idx, 1);
    do_wr(15'h1000, 8'h20);
    check("R8 release to idle", held, 0);
    check("R10 pulse on release", grant_change, 1);
    @(negedge clk);
    check("R10 release pulse one cycle", grant_change, 0);
    check("R8 stays idle", held, 0);
    do_rd(15'h1000, v);
    check("R7 released window", v, 8'h80);
  endtask

  task automatic t_top_locality();
    logic [7:0] v;
    do_wr(15'h4000, 8'h02);
    @(negedge clk);
    check("R5 grant to 4", active_idx, 4);
    do_wr(15'h0000, 8'h02);
    do_rd(15'h4000, v);
    check("R7 owner 4 sees waiter", v, 8'hA4);
    do_rd(15'h0000, v);
    check("R7 window 0 own request", v, 8'h82);
  endtask

  initial begin
    fork
      begin
        t_reset_and_init();
        t_grant_idle();
        t_pending_bits();
        t_foreign_release();
        t_scratch_and_alias();
        t_release_chain();
        t_top_locality();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule